// File: doc/BRIEF.md
# Eight-Channel Driver Fault Interrupt Controller

This block collects one raw fault level per line-driver channel and turns it into a small register bank with a single interrupt. Each fault input passes through a two-stage synchronizer. The synchronized value is mirrored into a status register. Any difference between the synchronized value and the stored status, whether the fault appeared or went away, marks that channel in an interrupt-status register. The interrupt-status bits are masked by a software-written enable register and combined into one registered interrupt output.

Software reaches the bank through a plain select/write/address/data port. A read returns its data one cycle after the request. Reading the interrupt-status register empties it, apart from any channel that changes in that same cycle. Event capture and the interrupt run only while the host-control input is high.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the status, enable and interrupt-status registers read 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Bit i of the status register at offset 05h equals `fault_raw[i]` as sampled three rising edges earlier. The bench reads it back through the bus.
- R3: While `host_mode` is 1, a change of status bit i in either direction sets bit i of the interrupt-status register at offset 09h. The bit stays set until it is cleared.
- R4: `irq` is 1 in the cycle after one in which `host_mode` is 1 and some interrupt-status bit and the same bit of the enable register are both 1. Otherwise `irq` is 0.
- R5: A read is a cycle with `bus_sel`=1 and `bus_wr`=0. It loads `bus_rdata` at the next edge with the register value from before that edge, and `bus_rdata` holds between reads. A read of 09h clears every interrupt-status bit that does not change in that cycle.
- R6: When a status change and a read of 09h fall in the same cycle, the changing bit remains set afterwards.
- R7: The enable register at 07h is written by a cycle with `bus_sel`=1 and `bus_wr`=1, and it reads back what was written. Writes to 05h, 09h and any other offset change nothing. Reads of offsets other than 05h, 07h and 09h return 0.
- R8: While `host_mode` is 0, no interrupt-status bit becomes set and `irq` is 0. The status register keeps following the faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode | input | 1 | Enables event capture and the interrupt |
| fault_raw | input | 8 | Asynchronous fault level per channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, loaded one cycle after a read |
| irq | output | 1 | Registered interrupt, active high |

## Verification
A stale status register shows up twice: reading 05h gives the wrong pattern, and the missing or extra change marks a wrong bit on the next read of 09h. Both appear within three cycles of the fault edge. A lost or spurious interrupt-status bit shows up at `irq` one cycle after the enable mask covers it, and in the next read of 09h. A wrong clear-on-read shows up as a nonzero second read, or as a lost event when a change collides with the read. An enable register that takes stray writes changes both the 07h read-back and the masking of `irq` from the following cycle.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h05;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h07;
  localparam logic [ADDR_W-1:0] OFS_IRQ_STS = 8'h09;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_EN     = 2'd2,
    RSEL_ISTAT  = 2'd3
  } rsel_e;

  function automatic rsel_e decode_addr(input logic [ADDR_W-1:0] a);
    rsel_e r;
    unique case (a)
      OFS_STATUS:  r = RSEL_STATUS;
      OFS_IRQ_EN:  r = RSEL_EN;
      OFS_IRQ_STS: r = RSEL_ISTAT;
      default:     r = RSEL_NONE;
    endcase
    return r;
  endfunction

  // new interrupt-status = survivors of a clear, plus fresh events
  function automatic logic [DATA_W-1:0] istat_next(input logic [DATA_W-1:0] cur,
                                                   input logic clr,
                                                   input logic [DATA_W-1:0] evt);
    return (clr ? '0 : cur) | evt;
  endfunction
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fault_evt_latch.sv
module fault_evt_latch #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_mode,
  input  logic [NCH-1:0] fault_s,
  input  logic           clr,
  output logic [NCH-1:0] status_q,
  output logic [NCH-1:0] istat_q,
  output logic [NCH-1:0] chg_evt
);
  logic [NCH-1:0] diff;
  logic [NCH-1:0] istat_d;

  assign diff    = fault_s ^ status_q;
  assign chg_evt = host_mode ? diff : '0;
  assign istat_d = fault_irq_pkg::istat_next(istat_q, clr, chg_evt);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          status_q[i] <= 1'b0;
          istat_q[i]  <= 1'b0;
        end else begin
          status_q[i] <= fault_s[i];
          istat_q[i]  <= istat_d[i];
        end
      end
    end
  endgenerate

  a_r2_status_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    status_q == $past(fault_s));
  a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg_evt) |=> ((istat_q & $past(chg_evt)) == $past(chg_evt)));
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && chg_evt == '0) |=> (istat_q == '0));
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && |chg_evt) |=> (istat_q == $past(chg_evt)));
  a_r8_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> ((istat_q & ~$past(istat_q)) == '0));
endmodule

// File: rtl/fault_regs.sv
module fault_regs #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = fault_irq_pkg::ADDR_W,
  parameter int unsigned DW  = fault_irq_pkg::DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [NCH-1:0] status,
  input  logic [NCH-1:0] istat,
  output logic [NCH-1:0] en_q,
  output logic           rd_clr,
  output logic [DW-1:0]  rdata_q
);
  import fault_irq_pkg::*;

  localparam int unsigned PAD = DW - NCH;

  rsel_e          sel;
  logic           rd_req;
  logic           we_en;
  logic [DW-1:0]  rmux;

  assign sel    = decode_addr(bus_addr);
  assign rd_req = bus_sel && !bus_wr;
  assign we_en  = bus_sel && bus_wr && (sel == RSEL_EN);
  assign rd_clr = rd_req && (sel == RSEL_ISTAT);

  function automatic logic [DW-1:0] widen(input logic [NCH-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  always_comb begin
    unique case (sel)
      RSEL_STATUS: rmux = widen(status);
      RSEL_EN:     rmux = widen(en_q);
      RSEL_ISTAT:  rmux = widen(istat);
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rmux;
  end

  a_r7_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we_en |=> $stable(en_q));
  a_r7_en_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_en |=> (en_q == $past(bus_wdata[NCH-1:0])));
  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata_q));
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (PAD == 0) || (rdata_q[DW-1:NCH] == '0));
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
  parameter int unsigned NCH         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_mode,
  input  logic [NCH-1:0]                    fault_raw,
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic [fault_irq_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [fault_irq_pkg::DATA_W-1:0]  bus_wdata,
  output logic [fault_irq_pkg::DATA_W-1:0]  bus_rdata,
  output logic                              irq
);
  logic [NCH-1:0] fault_s;
  logic [NCH-1:0] status_q;
  logic [NCH-1:0] istat_q;
  logic [NCH-1:0] chg_evt;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pending;
  logic           rd_clr;
  logic           irq_q;

  fault_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_raw), .q(fault_s)
  );

  fault_evt_latch #(.NCH(NCH)) u_evt (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .fault_s(fault_s),
    .clr(rd_clr), .status_q(status_q), .istat_q(istat_q), .chg_evt(chg_evt)
  );

  fault_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_q),
    .istat(istat_q), .en_q(en_q), .rd_clr(rd_clr), .rdata_q(bus_rdata)
  );

  assign pending = istat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= host_mode && (|pending);
  end
  assign irq = irq_q;

  a_r4_irq_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && |pending) |=> irq);
  a_r4_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> !irq);
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> !irq);
endmodule

// File: tb/fault_irq_ctrl_test.sv
module fault_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_mode = 1'b1;
  logic [7:0] fault_raw = '0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  // bench model
  logic [7:0] m_s1 = '0, m_s2 = '0, m_stat = '0, m_ist = '0, m_en = '0, m_rd = '0;
  logic       m_irq = 1'b0;

  fault_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .fault_raw(fault_raw),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h05) return m_stat;
    if (a == 8'h07) return m_en;
    if (a == 8'h09) return m_ist;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle; caller is at a falling edge
  task automatic tick(input logic [7:0] raw, input logic sel, input logic wr,
                      input logic [7:0] addr, input logic [7:0] wd);
    logic [7:0] chg;
    logic       clr;
    fault_raw = raw; bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    chg = host_mode ? (m_s2 ^ m_stat) : 8'h00;
    clr = sel && !wr && (addr == 8'h09);
    if (sel && !wr) m_rd = exp_read(addr);
    m_irq  = host_mode && ((m_ist & m_en) != 8'h00);
    m_ist  = (clr ? 8'h00 : m_ist) | chg;
    if (sel && wr && addr == 8'h07) m_en = wd;
    m_stat = m_s2; m_s2 = m_s1; m_s1 = raw;
    @(negedge clk);
    check("R4 irq", {7'b0, irq}, {7'b0, m_irq});
    check("R5 rdata", bus_rdata, m_rd);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(fault_raw, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic bus_read(input logic [7:0] addr, output logic [7:0] d);
    tick(fault_raw, 1'b1, 1'b0, addr, 8'h00);
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [7:0] addr, input logic [7:0] d);
    tick(fault_raw, 1'b1, 1'b1, addr, d);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    bus_read(8'h05, d); check("R1 status after reset", d, 8'h00);
    bus_read(8'h07, d); check("R1 enable after reset", d, 8'h00);
    bus_read(8'h09, d); check("R1 istat after reset", d, 8'h00);

    // R2 and R3: rising faults
    tick(8'h5A, 1'b0, 1'b0, 8'h00, 8'h00);
    idle(2);
    bus_read(8'h05, d); check("R2 status mirror", d, 8'h5A);
    bus_read(8'h09, d); check("R3 rising events", d, 8'h5A);
    bus_read(8'h09, d); check("R5 cleared by read", d, 8'h00);

    // R4 and R3: falling faults with full enable
    bus_write(8'h07, 8'hFF);
    tick(8'h50, 1'b0, 1'b0, 8'h00, 8'h00);
    idle(3);
    check("R4 irq raised", {7'b0, irq}, 8'h01);
    bus_read(8'h09, d); check("R3 falling events", d, 8'h0A);
    idle(2);
    check("R4 irq dropped after clear", {7'b0, irq}, 8'h00);

    // R4 masking: event on a disabled channel
    bus_write(8'h07, 8'hFE);
    tick(8'h51, 1'b0, 1'b0, 8'h00, 8'h00);
    idle(4);
    check("R4 masked channel no irq", {7'b0, irq}, 8'h00);
    bus_read(8'h09, d); check("R3 masked event recorded", d, 8'h01);

    // R7: ignored writes, unmapped reads
    bus_write(8'h05, 8'hFF);
    bus_write(8'h09, 8'hFF);
    bus_write(8'h33, 8'hAA);
    bus_read(8'h05, d); check("R7 status write ignored", d, 8'h51);
    bus_read(8'h09, d); check("R7 istat write ignored", d, 8'h00);
    bus_read(8'h07, d); check("R7 enable readback", d, 8'hFE);
    bus_read(8'h33, d); check("R7 unmapped read zero", d, 8'h00);

    // R6: change collides with read-clear
    tick(8'h53, 1'b0, 1'b0, 8'h00, 8'h00);
    idle(1);
    bus_read(8'h09, d); check("R6 read before event", d, 8'h00);
    bus_read(8'h09, d); check("R6 event survives clear", d, 8'h02);

    // R8: host control off
    host_mode = 1'b0;
    bus_write(8'h07, 8'hFF);
    tick(8'hAC, 1'b0, 1'b0, 8'h00, 8'h00);
    idle(4);
    check("R8 irq quiet", {7'b0, irq}, 8'h00);
    bus_read(8'h09, d); check("R8 no capture", d, 8'h00);
    bus_read(8'h05, d); check("R8 status still follows", d, 8'hAC);
    host_mode = 1'b1;
    idle(2);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] raw;
      int unsigned r;
      raw = fault_raw;
      if ($urandom_range(7) == 0) raw = raw ^ 8'($urandom());
      if ($urandom_range(199) == 0) host_mode = ~host_mode;
      r = $urandom_range(19);
      if (r < 2)       tick(raw, 1'b1, 1'b0, 8'h05, 8'h00);
      else if (r < 5)  tick(raw, 1'b1, 1'b0, 8'h09, 8'h00);
      else if (r < 6)  tick(raw, 1'b1, 1'b0, 8'h07, 8'h00);
      else if (r < 7)  tick(raw, 1'b1, 1'b0, 8'($urandom()), 8'h00);
      else if (r < 8)  tick(raw, 1'b1, 1'b1, 8'h07, 8'($urandom()));
      else if (r < 9)  tick(raw, 1'b1, 1'b1, 8'($urandom()), 8'($urandom()));
      else             tick(raw, 1'b0, 1'b0, 8'h00, 8'h00);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule